// File: doc/BRIEF.md
# Oversampled UART Receiver

This block turns an asynchronous serial receive line into characters. An internal divider makes a sample tick. Each bit period spans 16 ticks, or 8 when the faster mode is selected. The line is first synchronised and then cleaned by a three-sample majority filter. A falling edge starts a candidate start bit. The receiver accepts that start bit only if the line is still low half a bit later. After that it samples every following bit at its centre.

Each frame holds 5 to 9 data bits, sent least- or most-significant bit first. An optional parity bit and one stop bit follow. The finished character is held at the output with four status flags: parity error, framing error, overrun and break. The consumer takes the character with a one-cycle read acknowledge. The receiver also counts idle bit periods after each character and raises a timeout flag when the programmed idle time has passed.

Top module: `uart_os_rx`

## Requirements
- R1: A sample tick occurs once every `cfg_div_i`+1 clock cycles. One bit period is 16 ticks when `cfg_os8_i`=0 and 8 ticks when `cfg_os8_i`=1.
- R2: The line passes through a two-flop synchroniser and then a majority vote over the last three tick samples. A low pulse that reaches at most one tick sample has no effect on the received data.
- R3: A low filtered line in idle begins a start bit. The start bit is confirmed only if the line is still low half a bit period later. If it is not, the receiver returns to idle and produces no character.
- R4: `cfg_len_i` selects 5 to 9 data bits. Values below 5 act as 5 and values above 9 act as 9. Data appears right-justified in `rx_data_o`, with the unused upper bits at zero. With `cfg_msb_first_i`=0 the first received data bit lands in bit 0. With `cfg_msb_first_i`=1 it lands in bit length-1.
- R5: `cfg_parity_i` selects the parity mode: 0 or 3 means no parity bit, 1 means even, 2 means odd. When parity is enabled, one parity bit follows the data. `rx_par_err_o` is set when the data bits and the parity bit together break the selected rule.
- R6: The single stop bit is sampled at its centre. A low stop bit sets `rx_framing_err_o`. After a low stop bit the receiver ignores the line until it returns high.
- R7: When all data bits, the parity bit (if enabled) and the stop bit are low, both `rx_break_o` and `rx_framing_err_o` are set, and the data is zero.
- R8: When a character completes while `rx_valid_o` is high and `rd_ack_i` is low, the new character replaces the old one and `rx_overrun_o` is set.
- R9: `rd_ack_i` clears `rx_valid_o` and all four character flags in the next cycle, unless a character completes in the same cycle.
- R10: After each character, once `cfg_timeout_i` idle bit periods have passed since the centre of the stop bit, `rx_timeout_o` rises. It stays high until the next start bit is confirmed. A value of 0 turns the timeout off.
- R11: After synchronous reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Asynchronous receive line, idles high |
| cfg_div_i | input | 16 | Clock cycles per sample tick, minus one |
| cfg_os8_i | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| cfg_len_i | input | 4 | Data bits per character (5 to 9) |
| cfg_msb_first_i | input | 1 | 1: most significant bit is received first |
| cfg_parity_i | input | 2 | 0/3 none, 1 even, 2 odd |
| cfg_timeout_i | input | 8 | Idle timeout in bit periods, 0 turns it off |
| rd_ack_i | input | 1 | Consumer takes the held character |
| rx_valid_o | output | 1 | An unread character is held |
| rx_data_o | output | 9 | Received character, right-justified |
| rx_par_err_o | output | 1 | Parity error on the held character |
| rx_framing_err_o | output | 1 | Stop bit was low |
| rx_overrun_o | output | 1 | The held character replaced an unread one |
| rx_break_o | output | 1 | The whole frame was low |
| rx_timeout_o | output | 1 | The line has been idle past the programmed time |

## Verification
The hardest case to reach is a line that stays low for longer than a full frame. Here the receiver must report exactly one break character and must not start a new frame on the still-low line. The bench holds the line low for three frame lengths without reading. It then expects one character with break set and overrun clear. After releasing the line, it expects no further character. Filtering is tested at the edge of what the filter can see: a single clock of low pulse, both on an idle line and inside a data bit, must change nothing. A pulse of a few ticks passes the filter but must fail the half-bit start check.

// File: rtl/uart_os_rx_pkg.sv
// Shared constants and enumerations for the oversampled receiver.
package uart_os_rx_pkg;
    localparam int MAX_BITS = 9;
    localparam int MIN_BITS = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD
    } rx_state_e;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_OFF  = 2'd3
    } par_mode_e;
endpackage

// File: rtl/uart_os_rx_tick.sv
// Sample-tick divider: tick_o pulses once every div_i+1 clock cycles.
// Assumes div_i is quasi-static; a change simply takes effect at the
// next terminal count.
module uart_os_rx_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    assign tick_o = (cnt_q >= div_i);

    // Free-running divider counter that restarts at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    // R1: ticks are isolated unless the divide ratio is one
    a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (!tick_o || div_i == '0));
endmodule

// File: rtl/uart_os_rx_filter.sv
// Receive-line conditioner: two-flop synchroniser, then a majority vote
// over the three most recent tick samples. The output only moves on a
// tick. Assumes the idle line level is high.
module uart_os_rx_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic rx_i,
    output logic filt_o
);
    logic [1:0] sync_q;
    logic [2:0] win_q;
    logic [2:0] win_d;

    assign win_d = {win_q[1:0], sync_q[1]};

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_i};
    end

    // Shift one sample per tick and register the majority of three.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q  <= 3'b111;
            filt_o <= 1'b1;
        end else if (tick_i) begin
            win_q  <= win_d;
            filt_o <= (win_d[0] & win_d[1]) | (win_d[1] & win_d[2]) | (win_d[0] & win_d[2]);
        end
    end

    // R2: the filtered level never changes between ticks
    a_r2_filt_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(filt_o));
    // R2: a single low sample in a high window cannot pull the output low
    a_r2_single_low: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && win_q[1:0] == 2'b11) |=> filt_o);
endmodule

// File: rtl/uart_os_rx_timeout.sv
// Idle timeout: armed when a character completes, counts sample ticks,
// and raises flag_o after limit_i bit periods. A confirmed start bit
// clears and disarms it. limit_i == 0 never arms.
module uart_os_rx_timeout #(
    parameter int TO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            os8_i,
    input  logic [TO_W-1:0] limit_i,
    input  logic            arm_i,
    input  logic            clear_i,
    output logic            flag_o
);
    localparam int CW = TO_W + 4;

    logic          armed_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] target;

    // Limit expressed in ticks: bit periods times the oversampling factor.
    always_comb begin
        if (os8_i) target = CW'({limit_i, 3'b000});
        else       target = {limit_i, 4'b0000};
    end

    // Arm, count ticks while armed, and latch the flag on the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            flag_o  <= 1'b0;
        end else if (clear_i) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            flag_o  <= 1'b0;
        end else if (arm_i) begin
            armed_q <= (limit_i != '0);
            cnt_q   <= '0;
        end else if (armed_q && tick_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q + 1'b1 == target) begin
                flag_o  <= 1'b1;
                armed_q <= 1'b0;
            end
        end
    end

    // R10: a programmed value of zero never produces a timeout
    a_r10_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(limit_i) != '0);
    // R10: a confirmed start bit drops the flag
    a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !flag_o);
endmodule

// File: rtl/uart_os_rx.sv
// Oversampled asynchronous receiver. Finds the start bit, samples each
// bit at its centre, assembles 5..9 data bits in either order, checks
// parity and stop, and holds the character with its status until
// rd_ack_i. Assumes configuration changes only while the line is idle.
module uart_os_rx
    import uart_os_rx_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int TO_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_i,
    input  logic [DIV_W-1:0]    cfg_div_i,
    input  logic                cfg_os8_i,
    input  logic [3:0]          cfg_len_i,
    input  logic                cfg_msb_first_i,
    input  logic [1:0]          cfg_parity_i,
    input  logic [TO_W-1:0]     cfg_timeout_i,
    input  logic                rd_ack_i,
    output logic                rx_valid_o,
    output logic [MAX_BITS-1:0] rx_data_o,
    output logic                rx_par_err_o,
    output logic                rx_framing_err_o,
    output logic                rx_overrun_o,
    output logic                rx_break_o,
    output logic                rx_timeout_o
);
    localparam int CNT_W = 4;
    localparam int IDX_W = $clog2(MAX_BITS);

    logic tick;
    logic filt;

    rx_state_e           state_q;
    logic [CNT_W-1:0]    os_cnt_q;
    logic [IDX_W-1:0]    bit_idx_q;
    logic [MAX_BITS-1:0] shreg_q;
    logic                par_acc_q;
    logic                par_bit_q;

    logic [CNT_W-1:0] last_os;
    logic [CNT_W-1:0] half_last;
    logic [IDX_W-1:0] eff_len;
    logic [IDX_W-1:0] wr_idx;
    logic             par_en;
    logic             at_last;
    logic             done;
    logic             start_ok;

    uart_os_rx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (cfg_div_i),
        .tick_o (tick)
    );

    uart_os_rx_filter u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .rx_i   (rx_i),
        .filt_o (filt)
    );

    uart_os_rx_timeout #(.TO_W(TO_W)) u_timeout (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .os8_i   (cfg_os8_i),
        .limit_i (cfg_timeout_i),
        .arm_i   (done),
        .clear_i (start_ok),
        .flag_o  (rx_timeout_o)
    );

    // Derive counter limits, clamped length, parity enable and write index.
    always_comb begin
        last_os   = cfg_os8_i ? CNT_W'(7) : CNT_W'(15);
        half_last = cfg_os8_i ? CNT_W'(3) : CNT_W'(7);
        if (cfg_len_i < 4'(MIN_BITS))      eff_len = IDX_W'(MIN_BITS);
        else if (cfg_len_i > 4'(MAX_BITS)) eff_len = IDX_W'(MAX_BITS);
        else                               eff_len = cfg_len_i;
        par_en   = (cfg_parity_i == PAR_EVEN) || (cfg_parity_i == PAR_ODD);
        wr_idx   = cfg_msb_first_i ? (eff_len - 1'b1 - bit_idx_q) : bit_idx_q;
        at_last  = (os_cnt_q == last_os);
        done     = tick && (state_q == ST_STOP) && at_last;
        start_ok = tick && (state_q == ST_START) && (os_cnt_q == half_last) && !filt;
    end

    // Frame sequencer: start check, centre sampling, parity and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            os_cnt_q  <= '0;
            bit_idx_q <= '0;
            shreg_q   <= '0;
            par_acc_q <= 1'b0;
            par_bit_q <= 1'b0;
        end else if (tick) begin
            case (state_q)
                ST_IDLE: begin
                    if (!filt) begin
                        state_q  <= ST_START;
                        os_cnt_q <= '0;
                    end
                end
                ST_START: begin
                    if (os_cnt_q == half_last) begin
                        os_cnt_q  <= '0;
                        bit_idx_q <= '0;
                        shreg_q   <= '0;
                        par_acc_q <= 1'b0;
                        par_bit_q <= 1'b0;
                        state_q   <= filt ? ST_IDLE : ST_DATA;
                    end else begin
                        os_cnt_q <= os_cnt_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (at_last) begin
                        os_cnt_q        <= '0;
                        shreg_q[wr_idx] <= filt;
                        par_acc_q       <= par_acc_q ^ filt;
                        if (bit_idx_q == eff_len - 1'b1) state_q <= par_en ? ST_PAR : ST_STOP;
                        else                             bit_idx_q <= bit_idx_q + 1'b1;
                    end else begin
                        os_cnt_q <= os_cnt_q + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (at_last) begin
                        os_cnt_q  <= '0;
                        par_bit_q <= filt;
                        state_q   <= ST_STOP;
                    end else begin
                        os_cnt_q <= os_cnt_q + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (at_last) begin
                        os_cnt_q <= '0;
                        state_q  <= filt ? ST_IDLE : ST_HOLD;
                    end else begin
                        os_cnt_q <= os_cnt_q + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (filt) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Result holding register: load on completion, clear on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid_o       <= 1'b0;
            rx_data_o        <= '0;
            rx_par_err_o     <= 1'b0;
            rx_framing_err_o <= 1'b0;
            rx_overrun_o     <= 1'b0;
            rx_break_o       <= 1'b0;
        end else if (done) begin
            rx_valid_o       <= 1'b1;
            rx_data_o        <= shreg_q;
            rx_par_err_o     <= par_en && (par_acc_q ^ par_bit_q ^ (cfg_parity_i == PAR_ODD));
            rx_framing_err_o <= !filt;
            rx_overrun_o     <= rx_valid_o && !rd_ack_i;
            rx_break_o       <= (shreg_q == '0) && !filt && !(par_en && par_bit_q);
        end else if (rd_ack_i) begin
            rx_valid_o       <= 1'b0;
            rx_par_err_o     <= 1'b0;
            rx_framing_err_o <= 1'b0;
            rx_overrun_o     <= 1'b0;
            rx_break_o       <= 1'b0;
        end
    end

    // R3: data sampling only begins after a start bit that was still low at mid-bit
    a_r3_start_confirmed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && $past(state_q) == ST_START) |-> !$past(filt));
    // R6: after a low stop bit the sequencer stays parked while the line is low
    a_r6_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !filt) |=> state_q == ST_HOLD);
    // R7: a break is always also a framing error with zero data
    a_r7_break_frame: assert property (@(posedge clk) disable iff (!rst_n)
        rx_break_o |-> (rx_framing_err_o && rx_data_o == '0));
    // R8: overrun can only be flagged on a held character
    a_r8_overrun_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun_o |-> rx_valid_o);
    // R9: a read without a coincident completion empties the holding register
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_o && rd_ack_i && !done) |=> !rx_valid_o);
endmodule

// File: tb/uart_os_rx_tb.sv
module uart_os_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx = 1'b1;
    logic [15:0] cfg_div = 16'd1;
    logic        cfg_os8 = 1'b0;
    logic [3:0]  cfg_len = 4'd8;
    logic        cfg_msb = 1'b0;
    logic [1:0]  cfg_par = 2'd0;
    logic [7:0]  cfg_to = 8'd0;
    logic        rd_ack = 1'b0;
    logic        valid;
    logic [8:0]  data;
    logic        par_err, frm_err, ovr, brk, tmo;

    int n_tests = 0;
    int n_fail  = 0;
    int bitclk  = 32;
    bit finished = 0;

    always #2.5 clk = ~clk;

    uart_os_rx u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .rx_i             (rx),
        .cfg_div_i        (cfg_div),
        .cfg_os8_i        (cfg_os8),
        .cfg_len_i        (cfg_len),
        .cfg_msb_first_i  (cfg_msb),
        .cfg_parity_i     (cfg_par),
        .cfg_timeout_i    (cfg_to),
        .rd_ack_i         (rd_ack),
        .rx_valid_o       (valid),
        .rx_data_o        (data),
        .rx_par_err_o     (par_err),
        .rx_framing_err_o (frm_err),
        .rx_overrun_o     (ovr),
        .rx_break_o       (brk),
        .rx_timeout_o     (tmo)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic setup(input int div, input bit os8, input int len, input bit msb,
                         input int par, input int to);
        cfg_div = 16'(div);
        cfg_os8 = os8;
        cfg_len = 4'(len);
        cfg_msb = msb;
        cfg_par = 2'(par);
        cfg_to  = 8'(to);
        bitclk  = (os8 ? 8 : 16) * (div + 1);
    endtask

    task automatic idle_bits(input int n);
        rx = 1'b1;
        repeat (n * bitclk) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        rx = b;
        repeat (bitclk) @(negedge clk);
    endtask

    // a one-clock inverted pulse in the middle of the bit
    task automatic send_bit_glitch(input bit b);
        rx = b;
        repeat (bitclk / 2) @(negedge clk);
        rx = ~b;
        @(negedge clk);
        rx = b;
        repeat (bitclk - bitclk / 2 - 1) @(negedge clk);
    endtask

    task automatic send_frame(input int v, input int len, input bit msb, input int par,
                              input bit flip, input bit stop, input int glitch_at);
        bit acc = 1'b0;
        send_bit(1'b0);
        for (int i = 0; i < len; i++) begin
            bit b = msb ? v[len-1-i] : v[i];
            acc ^= b;
            if (i == glitch_at) send_bit_glitch(b);
            else                send_bit(b);
        end
        if (par == 1 || par == 2) send_bit(acc ^ (par == 2) ^ flip);
        send_bit(stop);
    endtask

    task automatic ack();
        @(negedge clk);
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 valid", valid, 0);
        chk("R11 data", data, 0);
        chk("R11 flags", {par_err, frm_err, ovr, brk, tmo}, 0);

        // R1 R4 R5: sweep oversampling, length, order and parity mode
        for (int os = 0; os < 2; os++)
            for (int len = 5; len <= 9; len++)
                for (int msb = 0; msb < 2; msb++)
                    for (int par = 0; par < 3; par++) begin
                        int mask = (1 << len) - 1;
                        setup(1, os[0], len, msb[0], par, 0);
                        idle_bits(2);
                        for (int k = 0; k < 2; k++) begin
                            int v = (k == 0) ? ((len * 53 + msb * 29 + par * 17 + os * 7 + 1) & mask)
                                             : (~(len * 53 + msb * 29 + par * 17 + os * 7 + 1) & mask);
                            send_frame(v, len, msb[0], par, 1'b0, 1'b1, -1);
                            idle_bits(1);
                            chk("R1 valid after frame", valid, 1);
                            chk("R4 data", data, v);
                            chk("R5 parity clean", par_err, 0);
                            chk("R6 stop clean", frm_err, 0);
                            ack();
                            chk("R9 read clears", valid, 0);
                        end
                    end

        // R1 other divide ratios
        for (int d = 0; d < 4; d += 3) begin
            setup(d, 1'b0, 8, 1'b0, 0, 0);
            idle_bits(2);
            send_frame(8'hA7, 8, 1'b0, 0, 1'b0, 1'b1, -1);
            idle_bits(1);
            chk("R1 divider data", data, 'hA7);
            ack();
        end

        // R5 parity errors, both modes
        for (int par = 1; par < 3; par++) begin
            setup(1, 1'b1, 7, 1'b1, par, 0);
            idle_bits(2);
            send_frame(7'h4B, 7, 1'b1, par, 1'b1, 1'b1, -1);
            idle_bits(1);
            chk("R5 parity error", par_err, 1);
            chk("R5 data kept", data, 'h4B);
            ack();
            chk("R9 flags cleared", par_err, 0);
        end

        // R4 length clamping
        setup(1, 1'b0, 3, 1'b0, 0, 0);
        idle_bits(2);
        send_frame(5'h16, 5, 1'b0, 0, 1'b0, 1'b1, -1);
        idle_bits(1);
        chk("R4 short length clamp", data, 'h16);
        ack();
        setup(1, 1'b0, 15, 1'b1, 0, 0);
        idle_bits(2);
        send_frame(9'h1C5, 9, 1'b1, 0, 1'b0, 1'b1, -1);
        idle_bits(1);
        chk("R4 long length clamp", data, 'h1C5);
        ack();

        // R6 framing error without break
        setup(1, 1'b0, 8, 1'b0, 0, 0);
        idle_bits(2);
        send_frame(8'h55, 8, 1'b0, 0, 1'b0, 1'b0, -1);
        idle_bits(1);
        chk("R6 framing error", frm_err, 1);
        chk("R7 not a break", brk, 0);
        chk("R6 data", data, 'h55);
        ack();

        // R7 break with even parity enabled
        setup(1, 1'b1, 7, 1'b0, 1, 0);
        idle_bits(2);
        send_frame(0, 7, 1'b0, 1, 1'b0, 1'b0, -1);
        idle_bits(1);
        chk("R7 break flag", brk, 1);
        chk("R7 break framing", frm_err, 1);
        chk("R7 break data", data, 0);
        ack();

        // R7 zero data but high odd parity bit is not a break
        setup(1, 1'b0, 8, 1'b0, 2, 0);
        idle_bits(2);
        send_frame(0, 8, 1'b0, 2, 1'b0, 1'b0, -1);
        idle_bits(1);
        chk("R7 high parity no break", brk, 0);
        chk("R7 high parity framing", frm_err, 1);
        ack();

        // R6 line held low for three frames: one break, no restart
        setup(1, 1'b0, 8, 1'b0, 0, 0);
        idle_bits(2);
        rx = 1'b0;
        repeat (30 * bitclk) @(negedge clk);
        chk("R6 long low one char", valid, 1);
        chk("R6 long low no overrun", ovr, 0);
        chk("R7 long low break", brk, 1);
        ack();
        idle_bits(3);
        chk("R6 no frame after release", valid, 0);

        // R8 overrun
        send_frame(8'h31, 8, 1'b0, 0, 1'b0, 1'b1, -1);
        idle_bits(1);
        send_frame(8'hC2, 8, 1'b0, 0, 1'b0, 1'b1, -1);
        idle_bits(1);
        chk("R8 overrun set", ovr, 1);
        chk("R8 newer data", data, 'hC2);
        ack();
        send_frame(8'h0F, 8, 1'b0, 0, 1'b0, 1'b1, -1);
        idle_bits(1);
        chk("R8 overrun clear after read", ovr, 0);
        ack();

        // R2 one-clock glitch on idle line, and inside a data bit
        rx = 1'b0;
        @(negedge clk);
        rx = 1'b1;
        idle_bits(3);
        chk("R2 idle glitch ignored", valid, 0);
        send_frame(8'h6D, 8, 1'b0, 0, 1'b0, 1'b1, 3);
        idle_bits(1);
        chk("R2 glitched bit data", data, 'h6D);
        ack();

        // R3 short low pulse passes the filter but fails the mid-bit check
        rx = 1'b0;
        repeat (6) @(negedge clk);
        rx = 1'b1;
        idle_bits(3);
        chk("R3 false start rejected", valid, 0);

        // R10 timeout of 4 bit periods
        setup(1, 1'b0, 8, 1'b0, 0, 4);
        idle_bits(2);
        send_frame(8'h99, 8, 1'b0, 0, 1'b0, 1'b1, -1);
        idle_bits(2);
        chk("R10 not yet timed out", tmo, 0);
        idle_bits(4);
        chk("R10 timed out", tmo, 1);
        ack();
        chk("R10 flag held after read", tmo, 1);
        send_frame(8'h12, 8, 1'b0, 0, 1'b0, 1'b1, -1);
        chk("R10 cleared by start", tmo, 0);
        ack();
        idle_bits(6);
        chk("R10 fires again", tmo, 1);

        // R10 zero disables
        setup(1, 1'b1, 8, 1'b0, 0, 0);
        send_frame(8'h21, 8, 1'b0, 0, 1'b0, 1'b1, -1);
        idle_bits(20);
        chk("R10 zero disables", tmo, 0);
        ack();

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule